// File: doc/BRIEF.md
# Byte-Wide EEPROM Access Sequencer

This block sits between a synchronous request port and an asynchronous, byte-wide, electrically erasable memory with a 9-bit address and an 8-bit data bus. A single-cycle request, either a read or a byte write, is expanded into a timed sequence on the memory's active-low select, output-gate and write strobes. Each phase lasts a whole number of clock cycles, set by a parameter.

A read selects the memory with its outputs gated on, waits the access time and captures the bus. A write presents the address and data and then pulses the write strobe low for a set number of cycles. The controller does not wait a fixed programming delay. It releases the bus and then reads the same address over and over. The memory returns the inverted top data bit until its internal programming ends. The controller stops polling once that bit agrees with the byte that was written. If the bit still disagrees after a set number of polls, the operation ends with an error flag.

Between operations the memory is held deselected, with the strobes and the data drivers inactive. Only one request is in flight at a time.

Top module: `eeprom_byte_ctrl`

## Requirements
- R1: After reset and whenever `busy` is low, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, and `done` and `err` are 0 after reset.
- R2: A request with `we`=0 holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD_CYC cycles. `rdata` then takes the bus value sampled in the last of those cycles. `done` rises RD_CYC cycles after the cycle following acceptance.
- R3: In a write, `mem_ce_n` is held low and `mem_oe_n` high for SETUP_CYC cycles before `mem_we_n` falls. `mem_we_n` then stays low for exactly WE_LOW_CYC cycles, and WE_LOW_CYC × 10 ns exceeds 10 ns.
- R4: `mem_a` stays constant while `mem_ce_n` remains low. On the cycle `mem_we_n` rises, `mem_dq_out` is unchanged, `mem_dq_oe` is 1, `mem_ce_n` is 0 and `mem_oe_n` is 1.
- R5: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and it was 0 in the cycle before any fall of `mem_oe_n`.
- R6: After the write strobe, the controller reads the written address repeatedly. It ends with `err`=0 on the first poll whose bit 7 equals bit 7 of the written byte, and bits 6..0 of polls have no effect.
- R7: If MAX_POLLS polls in a row show a bit 7 that differs, the write ends with `done` and `err`=1. A match on poll number MAX_POLLS still ends with `err`=0.
- R8: A `req` seen while `busy` is 1 is ignored: it starts no strobe activity and touches no other address.
- R9: `done` is high for a single cycle with `busy` high. In the next cycle `busy` is 0 and a new request can be accepted.
- R10: `err` keeps its value until the next accepted request and returns to 0 in the cycle after acceptance.
- R11: `rdata` changes only at the end of a read request; polls made during a write leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, sampled while idle |
| we | input | 1 | 1 = byte write, 0 = read |
| addr | input | 9 | Target byte address |
| wdata | input | 8 | Byte to write |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| err | output | 1 | Last write timed out while polling |
| mem_a | output | 9 | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_oe | output | 1 | Enable for data drivers toward memory |
| mem_dq_in | input | 8 | Data returned by memory |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |

## Verification
The match test and the poll-limit test are made on the same poll, so a correct bit 7 can arrive at the same moment the limit is reached. A memory model that counts poll reads provokes this. It returns the inverted bit for exactly MAX_POLLS-1 polls, and then for MAX_POLLS polls, so the final permitted poll matches in one case and misses in the other. The model's poll count must equal MAX_POLLS in both cases, with `err` clear only in the first. A second collision comes from requests held high through the completion cycle of a write. These must start nothing and leave the memory untouched at any other address.

// File: rtl/eepc_pkg.sv
package eepc_pkg;

    localparam int EEPC_AW = 9;
    localparam int EEPC_DW = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD     = 3'd1,
        ST_WSETUP = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WHOLD  = 3'd4,
        ST_PTURN  = 3'd5,
        ST_PREAD  = 3'd6,
        ST_FIN    = 3'd7
    } eepc_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } eepc_pins_t;

    typedef struct packed {
        logic               is_wr;
        logic [EEPC_AW-1:0] addr;
        logic [EEPC_DW-1:0] data;
    } eepc_op_t;

    localparam eepc_pins_t PINS_PARKED = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    function automatic eepc_pins_t pins_for(eepc_state_e s);
        eepc_pins_t p;
        p = PINS_PARKED;
        case (s)
            ST_RD, ST_PREAD: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
            end
            ST_WSETUP, ST_WHOLD: begin
                p.ce_n  = 1'b0;
                p.dq_oe = 1'b1;
            end
            ST_WPULSE: begin
                p.ce_n  = 1'b0;
                p.we_n  = 1'b0;
                p.dq_oe = 1'b1;
            end
            default: p = PINS_PARKED;
        endcase
        return p;
    endfunction

    function automatic logic poll_settled(logic [EEPC_DW-1:0] seen, logic [EEPC_DW-1:0] written);
        return seen[EEPC_DW-1] == written[EEPC_DW-1];
    endfunction

endpackage

// File: rtl/eepc_phase_timer.sv
module eepc_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/eepc_poll_tracker.sv
module eepc_poll_tracker #(
    parameter int MAX_POLLS = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam logic [PW-1:0] LIMIT_M1 = PW'(MAX_POLLS - 1);

    logic [PW-1:0] misses_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            misses_q <= '0;
        end else if (inc && misses_q != LIMIT_M1) begin
            misses_q <= misses_q + PW'(1);
        end
    end

    assign last = (misses_q == LIMIT_M1);
endmodule

// File: rtl/eepc_strobe_drv.sv
module eepc_strobe_drv
    import eepc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  eepc_state_e state_d,
    output logic        mem_ce_n,
    output logic        mem_oe_n,
    output logic        mem_we_n,
    output logic        mem_dq_oe
);
    eepc_pins_t pins_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q <= PINS_PARKED;
        end else begin
            pins_q <= pins_for(state_d);
        end
    end

    assign mem_ce_n  = pins_q.ce_n;
    assign mem_oe_n  = pins_q.oe_n;
    assign mem_we_n  = pins_q.we_n;
    assign mem_dq_oe = pins_q.dq_oe;
endmodule

// File: rtl/eepc_seq.sv
module eepc_seq
    import eepc_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int WE_LOW_CYC = 3,
    parameter int HOLD_CYC   = 1,
    parameter int TURN_CYC   = 1,
    parameter int RD_CYC     = 3,
    parameter int TW         = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic               we,
    input  logic [EEPC_AW-1:0] addr,
    input  logic [EEPC_DW-1:0] wdata,
    input  logic [EEPC_DW-1:0] mem_dq_in,
    input  logic               tmr_zero,
    input  logic               poll_last,
    output logic               tmr_load,
    output logic [TW-1:0]      tmr_val,
    output logic               poll_clr,
    output logic               poll_inc,
    output eepc_state_e        state_d,
    output logic               busy,
    output logic               done,
    output logic [EEPC_DW-1:0] rdata,
    output logic               err,
    output logic [EEPC_AW-1:0] mem_a,
    output logic [EEPC_DW-1:0] mem_dq_out
);
    eepc_state_e        state_q;
    eepc_op_t           op_q;
    logic [EEPC_DW-1:0] rdata_q;
    logic               err_q;
    logic               accept;
    logic               capture;
    logic               set_err;

    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        capture  = 1'b0;
        set_err  = 1'b0;
        poll_clr = 1'b0;
        poll_inc = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    poll_clr = 1'b1;
                    state_d  = we ? ST_WSETUP : ST_RD;
                end
            end
            ST_RD: begin
                if (tmr_zero) begin
                    capture = 1'b1;
                    state_d = ST_FIN;
                end
            end
            ST_WSETUP: if (tmr_zero) state_d = ST_WPULSE;
            ST_WPULSE: if (tmr_zero) state_d = ST_WHOLD;
            ST_WHOLD:  if (tmr_zero) state_d = ST_PTURN;
            ST_PTURN:  if (tmr_zero) state_d = ST_PREAD;
            ST_PREAD: begin
                if (tmr_zero) begin
                    if (poll_settled(mem_dq_in, op_q.data)) begin
                        state_d = ST_FIN;
                    end else if (poll_last) begin
                        set_err = 1'b1;
                        state_d = ST_FIN;
                    end else begin
                        poll_inc = 1'b1;
                        state_d  = ST_PTURN;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = (state_d != state_q);
        case (state_d)
            ST_RD, ST_PREAD: tmr_val = TW'(RD_CYC - 1);
            ST_WSETUP:       tmr_val = TW'(SETUP_CYC - 1);
            ST_WPULSE:       tmr_val = TW'(WE_LOW_CYC - 1);
            ST_WHOLD:        tmr_val = TW'(HOLD_CYC - 1);
            ST_PTURN:        tmr_val = TW'(TURN_CYC - 1);
            default:         tmr_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q.is_wr <= we;
                op_q.addr  <= addr;
                op_q.data  <= wdata;
                err_q      <= 1'b0;
            end
            if (set_err) begin
                err_q <= 1'b1;
            end
            if (capture) begin
                rdata_q <= mem_dq_in;
            end
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = (state_q == ST_FIN);
    assign rdata      = rdata_q;
    assign err        = err_q;
    assign mem_a      = op_q.addr;
    assign mem_dq_out = op_q.data;
endmodule

// File: rtl/eeprom_byte_ctrl.sv
module eeprom_byte_ctrl
    import eepc_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int WE_LOW_CYC = 3,
    parameter int HOLD_CYC   = 1,
    parameter int TURN_CYC   = 1,
    parameter int RD_CYC     = 3,
    parameter int MAX_POLLS  = 2000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic               we,
    input  logic [EEPC_AW-1:0] addr,
    input  logic [EEPC_DW-1:0] wdata,
    output logic               busy,
    output logic               done,
    output logic [EEPC_DW-1:0] rdata,
    output logic               err,
    output logic [EEPC_AW-1:0] mem_a,
    output logic [EEPC_DW-1:0] mem_dq_out,
    output logic               mem_dq_oe,
    input  logic [EEPC_DW-1:0] mem_dq_in,
    output logic               mem_ce_n,
    output logic               mem_oe_n,
    output logic               mem_we_n
);
    localparam int LEN_A   = (SETUP_CYC > WE_LOW_CYC) ? SETUP_CYC : WE_LOW_CYC;
    localparam int LEN_B   = (HOLD_CYC > TURN_CYC) ? HOLD_CYC : TURN_CYC;
    localparam int LEN_AB  = (LEN_A > LEN_B) ? LEN_A : LEN_B;
    localparam int LEN_MAX = (LEN_AB > RD_CYC) ? LEN_AB : RD_CYC;
    localparam int TW      = $clog2(LEN_MAX + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          poll_clr;
    logic          poll_inc;
    logic          poll_last;
    eepc_state_e   state_d;

    eepc_seq #(
        .SETUP_CYC (SETUP_CYC),
        .WE_LOW_CYC(WE_LOW_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .TURN_CYC  (TURN_CYC),
        .RD_CYC    (RD_CYC),
        .TW        (TW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .mem_dq_in (mem_dq_in),
        .tmr_zero  (tmr_zero),
        .poll_last (poll_last),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .poll_clr  (poll_clr),
        .poll_inc  (poll_inc),
        .state_d   (state_d),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .err       (err),
        .mem_a     (mem_a),
        .mem_dq_out(mem_dq_out)
    );

    eepc_phase_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    eepc_poll_tracker #(.MAX_POLLS(MAX_POLLS)) u_polls (
        .clk (clk),
        .rst (rst),
        .clr (poll_clr),
        .inc (poll_inc),
        .last(poll_last)
    );

    eepc_strobe_drv u_pins (
        .clk      (clk),
        .rst      (rst),
        .state_d  (state_d),
        .mem_ce_n (mem_ce_n),
        .mem_oe_n (mem_oe_n),
        .mem_we_n (mem_we_n),
        .mem_dq_oe(mem_dq_oe)
    );
endmodule

// File: rtl/eepc_checker.sv
module eepc_checker
    import eepc_pkg::*;
#(
    parameter int WE_LOW_CYC = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic               mem_ce_n,
    input logic               mem_oe_n,
    input logic               mem_we_n,
    input logic               mem_dq_oe,
    input logic [EEPC_AW-1:0] mem_a,
    input logic [EEPC_DW-1:0] mem_dq_out
);
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || mem_we_n) begin
            low_run <= '0;
        end else begin
            low_run <= low_run + 16'd1;
        end
    end

    p_idle_parked_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    p_we_width_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (low_run == 16'(WE_LOW_CYC)));

    p_we_needs_select_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    p_addr_steady_r4: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_a));

    p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> ($stable(mem_dq_out) && mem_dq_oe && !mem_ce_n && mem_oe_n));

    p_no_contention_r5: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_oe_n));

    p_release_first_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    p_err_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> busy ##1 (!done && !busy));
endmodule

bind eeprom_byte_ctrl eepc_checker #(.WE_LOW_CYC(WE_LOW_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_a     (mem_a),
    .mem_dq_out(mem_dq_out)
);

// File: tb/eeprom_byte_ctrl_tb.sv
module eeprom_byte_ctrl_tb;
    localparam int SETUP = 2;
    localparam int WLOW  = 3;
    localparam int HOLD  = 1;
    localparam int TURN  = 1;
    localparam int RDC   = 3;
    localparam int MAXP  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       we = 1'b0;
    logic [8:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       busy, done, err;
    logic [7:0] rdata;
    logic [8:0] mem_a;
    logic [7:0] mem_dq_out, mem_dq_in;
    logic       mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;

    int checks = 0;
    int bad = 0;
    int cyc_total = 0;

    always #5 clk = ~clk;

    eeprom_byte_ctrl #(
        .SETUP_CYC(SETUP), .WE_LOW_CYC(WLOW), .HOLD_CYC(HOLD),
        .TURN_CYC(TURN), .RD_CYC(RDC), .MAX_POLLS(MAXP)
    ) u_dut (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .busy(busy), .done(done), .rdata(rdata), .err(err),
        .mem_a(mem_a), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n)
    );

    // memory model: self-timed programming ends after a set number of poll reads
    logic [7:0] dev_mem [0:511];
    logic [8:0] lat_a;
    logic [7:0] pd;
    logic       prog = 1'b0;
    logic       dirty_knob = 1'b0;
    logic       dirty_now = 1'b0;
    int         pend = 0;
    int         hold_polls = 0;
    int         n_writes = 0;
    int         n_reads = 0;
    int         stray = 0;
    logic [8:0] watch_a = '0;
    logic [7:0] dev_out;
    wire        rd_act = !mem_ce_n && !mem_oe_n;

    initial begin
        for (int i = 0; i < 512; i++) dev_mem[i] = 8'hFF;
    end

    always @(negedge mem_we_n) if (mem_ce_n === 1'b0) lat_a = mem_a;

    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0 && mem_oe_n === 1'b1) begin
            dev_mem[lat_a] = mem_dq_out;
            pd = mem_dq_out;
            prog = 1'b1;
            pend = hold_polls;
            n_writes++;
        end
    end

    always @(posedge rd_act) begin
        n_reads++;
        if (mem_a != watch_a) stray++;
        dirty_now = 1'b0;
        if (prog) begin
            if (pend == 0) begin
                prog = 1'b0;
                dirty_now = dirty_knob;
            end else begin
                pend--;
            end
        end
    end

    always_comb begin
        if (prog) dev_out = ~pd;
        else if (dirty_now) dev_out = {pd[7], ~pd[6:0]};
        else dev_out = dev_mem[mem_a];
    end
    assign mem_dq_in = rd_act ? dev_out : 8'h00;

    // strobe shape monitor
    int   ce_run = 0;
    int   setup_seen = 0;
    int   low_cnt = 0;
    int   last_low = 0;
    logic prev_we = 1'b1;
    always @(negedge clk) begin
        if (!mem_we_n && prev_we) begin
            setup_seen = ce_run;
            low_cnt = 1;
        end else if (!mem_we_n) begin
            low_cnt++;
        end
        if (mem_we_n && !prev_we) last_low = low_cnt;
        if (mem_ce_n || !mem_we_n) ce_run = 0; else ce_run++;
        prev_we = mem_we_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input bit w, input [8:0] a, input [7:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; watch_a = a;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 pins parked", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        chk(!busy && !done && !err, "R1 status clear", {busy, done, err}, 0);
    endtask

    task automatic t_read(input [8:0] a, input [7:0] exp);
        int cyc;
        int r0;
        r0 = n_reads;
        issue(1'b0, a, 8'h00);
        chk(busy == 1'b1, "R9 busy after accept", busy, 1);
        wait_done(cyc);
        chk(cyc == RDC, "R2 read latency", cyc, RDC);
        chk(rdata == exp, "R2 read data", rdata, exp);
        chk(n_reads - r0 == 1, "R2 single bus read", n_reads - r0, 1);
        chk(busy == 1'b1, "R9 busy with done", busy, 1);
        @(negedge clk);
        chk(!done && !busy, "R9 done single cycle", {done, busy}, 0);
    endtask

    task automatic t_write(input [8:0] a, input [7:0] d, input int hp, input bit dirty,
                           input bit exp_err, input int exp_polls, input string tag);
        int cyc;
        int r0;
        int w0;
        logic [7:0] rd0;
        hold_polls = hp;
        dirty_knob = dirty;
        r0 = n_reads;
        w0 = n_writes;
        rd0 = rdata;
        issue(1'b1, a, d);
        wait_done(cyc);
        chk(done == 1'b1, {tag, " done seen"}, done, 1);
        chk(err == exp_err, {tag, " err"}, err, exp_err);
        chk(n_reads - r0 == exp_polls, {tag, " poll count"}, n_reads - r0, exp_polls);
        chk(n_writes - w0 == 1, "R3 one write pulse", n_writes - w0, 1);
        chk(dev_mem[a] == d, "R4 byte stored", dev_mem[a], d);
        chk(setup_seen == SETUP, "R3 setup before strobe", setup_seen, SETUP);
        chk(last_low == WLOW, "R3 strobe width", last_low, WLOW);
        chk(rdata == rd0, "R11 rdata untouched by polls", rdata, rd0);
        @(negedge clk);
        dirty_knob = 1'b0;
    endtask

    task automatic t_busy_ignore;
        int cyc;
        int w0;
        int s0;
        w0 = n_writes;
        s0 = stray;
        hold_polls = 2;
        issue(1'b1, 9'h044, 8'h9C);
        req = 1'b1; we = 1'b0; addr = 9'h1F0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
        req = 1'b0;
        chk(n_writes - w0 == 1, "R8 no extra write", n_writes - w0, 1);
        chk(stray == s0, "R8 no stray address", stray - s0, 0);
        chk(!busy && !done, "R8 idle after held req", {busy, done}, 0);
        repeat (2) @(negedge clk);
        chk(mem_ce_n == 1'b1, "R8 no strobe activity", mem_ce_n, 1);
    endtask

    initial begin
        t_reset();
        t_read(9'h055, 8'hFF);
        t_write(9'h123, 8'hA5, 2, 1'b0, 1'b0, 3, "R6 poll until bit7");
        t_read(9'h123, 8'hA5);
        t_write(9'h0FF, 8'h3C, 0, 1'b0, 1'b0, 1, "R6 low bit7 byte");
        t_write(9'h010, 8'h81, 1, 1'b1, 1'b0, 2, "R6 low bits ignored");
        t_write(9'h020, 8'h77, MAXP, 1'b0, 1'b1, MAXP, "R7 timeout");
        issue(1'b0, 9'h020, 8'h00);
        chk(err == 1'b0, "R10 err cleared on accept", err, 0);
        begin
            int cyc;
            wait_done(cyc);
            chk(rdata == 8'h77, "R2 read after timeout", rdata, 8'h77);
        end
        @(negedge clk);
        t_write(9'h1AB, 8'hC3, MAXP - 1, 1'b0, 1'b0, MAXP, "R7 match on last poll");
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    always @(negedge clk) begin
        cyc_total++;
        if (cyc_total > 100000) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 100000);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule